// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block computes the product of two 32-bit operands over several clock cycles and optionally adds an accumulate value to it. One datapath serves six variants: a short multiply and a short multiply-accumulate that keep only the low 32 bits, and a signed or unsigned long multiply that keeps all 64 bits, each with or without a 64-bit accumulate. A surrounding core fetches the operands and writes the result back; this unit only does the arithmetic and reports negative and zero flags.

A one-cycle start pulse captures the operands, the accumulate value and the mode controls. The unit then stays busy for a fixed number of cycles. It adds one radix-2^BPC digit of the extended multiplier per cycle. After that it raises done for one cycle, and the result and flags are valid from that cycle on. The inputs may change freely once start has been seen.

Top module: `mac_unit`

## Requirements
- R1: After reset, busy_o, done_o, result_o, flag_n_o and flag_z_o are all 0.
- R2: A start_i pulse while busy_o is 0 samples all operand and mode inputs in that cycle. busy_o is then high for exactly STEPS = 2*W/BPC cycles (16 by default), followed by done_o high for exactly one cycle with busy_o low.
- R3: A start_i pulse while busy_o is 1 is ignored: the running operation ends on schedule with its own result, and no extra done_o pulse follows.
- R4: Short multiply (long_i=0, acc_en_i=0): result_o[31:0] is the low 32 bits of op_a_i*op_b_i and result_o[63:32] is 0, whatever signed_i is.
- R5: Short multiply-accumulate (long_i=0, acc_en_i=1): result_o[31:0] is (op_a_i*op_b_i + acc_i[31:0]) mod 2^32 and result_o[63:32] is 0.
- R6: Unsigned long multiply (long_i=1, signed_i=0, acc_en_i=0): result_o is the 64-bit product of the zero-extended operands.
- R7: Signed long multiply (long_i=1, signed_i=1, acc_en_i=0): result_o is the 64-bit two's-complement product of the sign-extended operands.
- R8: Long accumulate (long_i=1, acc_en_i=1): result_o is (long product + acc_i) mod 2^64, for both signednesses.
- R9: When set_flags_i was 1 at start, flag_n_o from the done cycle onward equals result_o[31] for short forms and result_o[63] for long forms.
- R10: When set_flags_i was 1 at start, flag_z_o from the done cycle onward is 1 exactly when all 64 bits of result_o are 0.
- R11: When set_flags_i was 0 at start, flag_n_o and flag_z_o keep the values they had before the operation.
- R12: result_o changes only in a cycle where done_o is 1 and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier |
| acc_i | input | 64 | Accumulate value {hi, lo}; short forms use the low half |
| acc_en_i | input | 1 | 1 adds the accumulate value |
| long_i | input | 1 | 1 selects a 64-bit result |
| signed_i | input | 1 | 1 selects signed operands for long forms |
| set_flags_i | input | 1 | 1 updates the N/Z flags at the end |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result; upper half 0 for short forms |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The assertions check the handshake on every cycle: busy and done are never high together, an accepted start leads to busy, and each done pulse follows exactly STEPS busy cycles, which also catches a restart during a busy run. They also hold the result and flags steady outside done, and tie the flags and the zeroed upper half to the result and latched mode. Only the bench scenarios show that the arithmetic is right for each of the six variants. The same holds for sign extension at the extreme operands, the wrap of the accumulate sums, and the operand values actually kept when a start is ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Operation controls sampled at start
  typedef struct packed {
    logic accum;     // add the accumulate value
    logic wide;      // keep the full double-width result
    logic sgn;       // signed operands (wide forms)
    logic upd_flags; // update N/Z at the end
  } mac_op_t;

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2*W-1:0] acc_i,
  input  mac_op_t        op_i,
  output logic [2*W-1:0] mcand_o,
  output logic [2*W-1:0] mplier_o,
  output logic [2*W-1:0] acc_init_o
);
  localparam int unsigned PW = 2 * W;

  // Sign- or zero-extend one operand to the double width
  function automatic logic [PW-1:0] extend(input logic [W-1:0] v, input logic sx);
    return {{W{sx & v[W-1]}}, v};
  endfunction

  // Starting value of the running sum
  function automatic logic [PW-1:0] seed(input logic [PW-1:0] acc, input logic use_acc,
                                         input logic wide);
    if (!use_acc) return '0;
    if (wide) return acc;
    return {{W{1'b0}}, acc[W-1:0]};
  endfunction

  // Short forms keep only the low half, where signedness makes no difference
  logic sign_ext;
  assign sign_ext   = op_i.sgn & op_i.wide;
  assign mcand_o    = extend(a_i, sign_ext);
  assign mplier_o   = extend(b_i, sign_ext);
  assign acc_init_o = seed(acc_i, op_i.accum, op_i.wide);

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl #(
  parameter int unsigned STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STEPS + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign accept_o = start_i & ~busy_q;
  assign step_o   = busy_q;
  assign last_o   = busy_q & (cnt_q == CW'(1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        cnt_q  <= CW'(STEPS);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mac_shift_add_core.sv
module mac_shift_add_core #(
  parameter int unsigned PW  = 64,
  parameter int unsigned BPC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [PW-1:0] mcand_i,
  input  logic [PW-1:0] mplier_i,
  input  logic [PW-1:0] acc_i,
  output logic [PW-1:0] sum_next_o
);
  // Multiple of the multiplicand selected by one multiplier digit
  function automatic logic [PW-1:0] digit_term(input logic [PW-1:0] m, input logic [BPC-1:0] d);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < int'(BPC); i++) begin
      if (d[i]) s = s + (m << i);
    end
    return s;
  endfunction

  logic [PW-1:0] mcand_q, mplier_q, sum_q;

  // Sum after the current digit, taken by the top on the last step
  assign sum_next_o = sum_q + digit_term(mcand_q, mplier_q[BPC-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      sum_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      sum_q    <= acc_i;
    end else if (step_i) begin
      mcand_q  <= mcand_q << BPC;
      mplier_q <= mplier_q >> BPC;
      sum_q    <= sum_next_o;
    end
  end

endmodule

// File: rtl/mac_flag_gen.sv
module mac_flag_gen #(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] sum_i,
  input  logic           wide_i,
  output logic [2*W-1:0] result_o,
  output logic           neg_o,
  output logic           zero_o
);
  localparam int unsigned PW = 2 * W;

  // Short forms clear the upper half
  function automatic logic [PW-1:0] shape(input logic [PW-1:0] s, input logic wide);
    return wide ? s : {{W{1'b0}}, s[W-1:0]};
  endfunction

  assign result_o = shape(sum_i, wide_i);
  assign neg_o    = wide_i ? result_o[PW-1] : result_o[W-1];
  assign zero_o   = (result_o == '0);

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned BPC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   op_a_i,
  input  logic [W-1:0]   op_b_i,
  input  logic [2*W-1:0] acc_i,
  input  logic           acc_en_i,
  input  logic           long_i,
  input  logic           signed_i,
  input  logic           set_flags_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] result_o,
  output logic           flag_n_o,
  output logic           flag_z_o
);
  localparam int unsigned PW    = 2 * W;
  localparam int unsigned STEPS = PW / BPC;

  mac_op_t       op_in;
  logic [PW-1:0] mcand_ext, mplier_ext, acc_seed, sum_next, shaped;
  logic          start_accept, step_en, last_step, fin_neg, fin_zero;
  logic          wide_q, flags_q;
  logic [PW-1:0] result_q;
  logic          n_q, z_q;

  assign op_in = '{accum: acc_en_i, wide: long_i, sgn: signed_i, upd_flags: set_flags_i};

  mac_operand_prep #(.W(W)) u_prep (
    .a_i(op_a_i), .b_i(op_b_i), .acc_i(acc_i), .op_i(op_in),
    .mcand_o(mcand_ext), .mplier_o(mplier_ext), .acc_init_o(acc_seed)
  );

  mac_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(start_accept), .step_o(step_en), .last_o(last_step),
    .busy_o(busy_o), .done_o(done_o)
  );

  mac_shift_add_core #(.PW(PW), .BPC(BPC)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(start_accept), .step_i(step_en),
    .mcand_i(mcand_ext), .mplier_i(mplier_ext), .acc_i(acc_seed),
    .sum_next_o(sum_next)
  );

  mac_flag_gen #(.W(W)) u_flags (
    .sum_i(sum_next), .wide_i(wide_q),
    .result_o(shaped), .neg_o(fin_neg), .zero_o(fin_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q   <= 1'b0;
      flags_q  <= 1'b0;
      result_q <= '0;
      n_q      <= 1'b0;
      z_q      <= 1'b0;
    end else begin
      if (start_accept) begin
        wide_q  <= op_in.wide;
        flags_q <= op_in.upd_flags;
      end
      if (last_step) begin
        result_q <= shaped;
        if (flags_q) begin
          n_q <= fin_neg;
          z_q <= fin_zero;
        end
      end
    end
  end

  assign result_o = result_q;
  assign flag_n_o = n_q;
  assign flag_z_o = z_q;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned STEPS = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accept,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] result_o,
  input logic           flag_n_o,
  input logic           flag_z_o,
  input logic           mode_wide,
  input logic           mode_flags
);
  // Length of the current busy run
  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy_o);
  // A restart while busy (R3) would stretch the run past STEPS
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_len == STEPS);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o));
  p_short_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mode_wide) |-> (result_o[2*W-1:W] == '0));
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && mode_flags) |-> $stable({flag_n_o, flag_z_o}));
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_flags) |-> (flag_z_o == (result_o == '0)));
  p_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_flags) |-> (flag_n_o == (mode_wide ? result_o[2*W-1] : result_o[W-1])));

endmodule

bind mac_unit mac_unit_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(start_accept), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
  .mode_wide(wide_q), .mode_flags(flags_q)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
  localparam int W = 32;
  localparam int BPC = 4;
  localparam int STEPS = 2 * W / BPC;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [63:0] acc_i = '0;
  logic acc_en_i = 1'b0, long_i = 1'b0, signed_i = 1'b0, set_flags_i = 1'b0;
  logic busy_o, done_o, flag_n_o, flag_z_o;
  logic [63:0] result_o;

  int errors = 0;
  int checks = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  mac_unit #(.W(W), .BPC(BPC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .acc_i(acc_i), .acc_en_i(acc_en_i), .long_i(long_i), .signed_i(signed_i),
    .set_flags_i(set_flags_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc, input bit use_acc,
                                        input bit lng, input bit sgn);
    logic signed [63:0] sa, sb;
    logic [63:0] p;
    logic [31:0] p32;
    if (lng) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      if (sgn) p = sa * sb;
      else p = {32'b0, a} * {32'b0, b};
      if (use_acc) p = p + acc;
      return p;
    end
    p32 = a * b;
    if (use_acc) p32 = p32 + acc[31:0];
    return {32'b0, p32};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                        input bit use_acc, input bit lng, input bit sgn, input bit fl,
                        input bit poke);
    logic [63:0] exp;
    string req;
    int j;
    req = lng ? (use_acc ? "R8" : (sgn ? "R7" : "R6")) : (use_acc ? "R5" : "R4");
    exp = model(a, b, acc, use_acc, lng, sgn);
    @(negedge clk);
    op_a_i = a; op_b_i = b; acc_i = acc;
    acc_en_i = use_acc; long_i = lng; signed_i = sgn; set_flags_i = fl;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // Inputs are only sampled at start (R2)
    op_a_i = $urandom; op_b_i = $urandom; acc_i = {$urandom, $urandom};
    acc_en_i = ~use_acc; long_i = ~lng; signed_i = ~sgn; set_flags_i = ~fl;
    check(busy_o === 1'b1, "R2", "busy after start", 64'(busy_o), 64'd1);
    j = 0;
    while (done_o !== 1'b1 && j < 40) begin
      @(negedge clk);
      j++;
      start_i = poke && (j == 4);  // R3: start while busy
    end
    start_i = 1'b0;
    check(j == STEPS, poke ? "R3" : "R2", "cycles to done", 64'(j), 64'(STEPS));
    check(busy_o === 1'b0, "R2", "busy in done cycle", 64'(busy_o), 64'd0);
    check(result_o === exp, poke ? "R3" : req, "result", result_o, exp);
    if (fl) begin
      exp_n = lng ? exp[63] : exp[31];
      exp_z = (exp == 64'd0);
    end
    check(flag_n_o === exp_n, fl ? "R9" : "R11", "flag N", 64'(flag_n_o), 64'(exp_n));
    check(flag_z_o === exp_z, fl ? "R10" : "R11", "flag Z", 64'(flag_z_o), 64'(exp_z));
    @(negedge clk);
    check(done_o === 1'b0, "R2", "done single pulse", 64'(done_o), 64'd0);
    repeat (poke ? 20 : 2) begin
      @(negedge clk);
      if (poke) check(done_o === 1'b0, "R3", "no extra done", 64'(done_o), 64'd0);
    end
    check(result_o === exp, "R12", "result held", result_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240917);
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1", "busy/done in reset",
          {62'b0, busy_o, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_o === 64'd0, "R1", "result after reset", result_o, 64'd0);
    check({flag_n_o, flag_z_o} === 2'b00, "R1", "flags after reset",
          64'({flag_n_o, flag_z_o}), 64'd0);

    // Directed corners
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0, 1, 1, 1, 0);  // R7: -1*-1
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0, 1, 0, 1, 0);  // R6
    run_op(32'h8000_0000, 32'h8000_0000, 64'd0, 0, 1, 1, 1, 0);  // R7: min*min
    run_op(32'h8000_0000, 32'h0000_0001, 64'd0, 0, 1, 1, 1, 0);  // R7/R9 negative
    run_op(32'h0001_0000, 32'h0001_0000, 64'h0, 1, 0, 0, 1, 0);  // R5: low half zero, Z=1
    run_op(32'h1234_5678, 32'h0000_0010, 64'd0, 0, 0, 0, 0, 0);  // R11: flags kept
    run_op(32'h0000_0002, 32'hC000_0000, 64'd0, 0, 0, 1, 1, 0);  // R4/R9 N from bit 31
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 64'h0000_0000_0000_0001, 1, 1, 1, 1, 0); // R8 -> 0
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 1, 0); // R8 wrap
    run_op(32'd0, 32'hDEAD_BEEF, 64'd0, 0, 1, 0, 1, 0);          // R10 zero long
    run_op(32'h0000_0003, 32'h0000_0005, 64'd0, 0, 0, 0, 1, 1);  // R3 poke

    for (int k = 0; k < 150; k++) begin
      run_op($urandom, $urandom, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), (k % 10) == 9);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule